// File: doc/BRIEF.md
# Two-Wire Serial Control Register File

This block is a slave on a two-wire serial bus (clock and data lines, data open-drain) that holds the control bytes of a system clock generator. Both bus lines are sampled by a fast system clock, so all of the block's logic runs in that one clock domain. The block recognises its own 7-bit device address. It then takes a block-write frame and loads its registers from register 0 upward, one register for each data byte. It can also stream the same registers back to the bus master in the same order.

The master must always send two header bytes after the address: a command byte and a count byte. The block acknowledges both and discards their values. Every transfer starts at register 0, whatever the header says. Eleven registers (0 to 10) can be written. Two identification bytes follow them and cannot be written. The contents of registers 2 to 5 drive the parallel outputs directly: per-output clock enables, two skew codes, and the two processor clock enables.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: A synchronous reset loads registers 2, 3 and 4 with 0xFF, register 5 with 0x93, register 7 with 0x20 and registers 0, 1, 6, 8, 9 and 10 with 0x00. Only reset changes these values; bus START and STOP conditions leave them alone.
- R2: The block acknowledges (pulls data low in the ninth bit) an address byte whose upper 7 bits equal SLAVE_ADDR. For any other address it does not acknowledge, and it does not drive the data line again until the next START.
- R3: The block acknowledges the first and second bytes after a write address and does not store them.
- R4: Write data bytes land in register 0, 1, 2 and so on, in that order, and each one is acknowledged.
- R5: Register 11 always reads 0x50 and register 12 always reads 0x12. A write to either is acknowledged and discarded.
- R6: Data bytes beyond the thirteenth are acknowledged and discarded.
- R7: A STOP or a repeated START returns the register pointer to 0.
- R8: An address byte whose bit 0 is 1 starts a read. The block returns register 0, 1, 2 and so on, MSB first. Positions past register 12 read 0xFF. A master not-acknowledge ends the read.
- R9: sdram_en_o[7:0] equals register 2. sdram_en_o[11:8] equals register 4 bits 4:1. sdram_free_en_o equals register 4 bit 0. pci_en_o equals register 3. mid_en_o[2:0] equals register 4 bits 7:5. In all of these, 1 means the output is enabled.
- R10: cpu_sdram_skew_o equals register 5 bits 7:5, cpu_mid_skew_o equals register 5 bits 4:2, and cpu_en_o[1:0] equals register 5 bits 1:0.
- R11: sda_oe_o (1 pulls the data line low) changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sdram_en_o | output | 12 | Memory clock enables 11..0 |
| sdram_free_en_o | output | 1 | Enable of the free-running memory clock |
| pci_en_o | output | 8 | Peripheral bus clock enables 7..0 |
| mid_en_o | output | 3 | 66 MHz-class chipset clock enables 2..0 |
| cpu_en_o | output | 2 | Processor clock enables 1..0 |
| cpu_sdram_skew_o | output | 3 | Processor-to-memory skew code |
| cpu_mid_skew_o | output | 3 | Processor-to-chipset skew code |

## Verification
The bench builds the block with the default device address 0x69 and two synchroniser stages. With two stages, a bus event is seen about three system clocks after it happens, which allows a short bit period. That brings long frames within the run budget: writes that go past register 12, reads that go past register 12, and a repeated START in the middle of a frame. A foreign address, 0x2A, is also driven, so the not-acknowledge path and the silent wait until the next START are both exercised.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int NUM_REGS = 13;
  localparam int NUM_RW   = 11;
  localparam int PTR_W    = $clog2(NUM_REGS + 1);
  localparam int BYTE_W   = 8;

  localparam logic [BYTE_W-1:0] ID_HI    = 8'h50;
  localparam logic [BYTE_W-1:0] ID_LO    = 8'h12;
  localparam logic [BYTE_W-1:0] PAST_END = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT
  } twi_state_t;

  typedef enum logic [1:0] {
    P_ADDR, P_CMD, P_CNT, P_DATA
  } twi_phase_t;

  function automatic logic [BYTE_W-1:0] power_up_value(input int idx);
    case (idx)
      2, 3, 4: return 8'hFF;
      5:       return 8'h93;
      7:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  assign scl_q     = scl_sr[STAGES-1];
  assign sda_q     = sda_sr[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  twi_state_t        state;
  twi_phase_t        phase;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [PTR_W-1:0]  ptr;
  logic              rw;

  assign rd_ptr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= P_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= S_RX;
        phase   <= P_ADDR;
        bit_cnt <= '0;
        ptr     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        ptr    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              case (phase)
                P_ADDR: begin
                  if (shreg[7:1] == SLAVE_ADDR) begin
                    rw     <= shreg[0];
                    sda_oe <= 1'b1;
                    state  <= S_RX_ACK;
                    phase  <= P_CMD;
                  end else begin
                    state <= S_WAIT;
                  end
                end
                P_CMD: begin
                  sda_oe <= 1'b1;
                  state  <= S_RX_ACK;
                  phase  <= P_CNT;
                end
                P_CNT: begin
                  sda_oe <= 1'b1;
                  state  <= S_RX_ACK;
                  phase  <= P_DATA;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  state   <= S_RX_ACK;
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  if (ptr != PTR_END) ptr <= ptr + 1'b1;
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= 4'd1;
                state   <= S_TX;
                if (ptr != PTR_END) ptr <= ptr + 1'b1;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_TX_ACK;
              end else begin
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~shreg[BYTE_W-2];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise && sda_q) begin
              state <= S_WAIT;
            end else if (scl_fall) begin
              shreg   <= rd_data;
              sda_oe  <= ~rd_data[BYTE_W-1];
              bit_cnt <= 4'd1;
              state   <= S_TX;
              if (ptr != PTR_END) ptr <= ptr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && !$past(start_det || stop_det)) |-> $stable(sda_oe));

  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> !sda_oe);

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R4
  bitcnt_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 4'd8);
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] grp_sdram,
  output logic [BYTE_W-1:0] grp_pci,
  output logic [BYTE_W-1:0] grp_misc,
  output logic [BYTE_W-1:0] grp_cpu
);
  logic [BYTE_W-1:0]        rw_q [NUM_RW];
  logic [NUM_RW*BYTE_W-1:0] rw_flat;
  logic [NUM_RW*BYTE_W-1:0] init_flat;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        rw_q[g] <= power_up_value(g);
      else if (wr_en && wr_addr == PTR_W'(g))
        rw_q[g] <= wr_data;
    end
    assign rw_flat[g*BYTE_W +: BYTE_W]   = rw_q[g];
    assign init_flat[g*BYTE_W +: BYTE_W] = power_up_value(g);
  end

  always_comb begin
    rd_data = PAST_END;
    for (int i = 0; i < NUM_RW; i++)
      if (rd_ptr == PTR_W'(i)) rd_data = rw_q[i];
    if (rd_ptr == PTR_W'(NUM_RW))     rd_data = ID_HI;
    if (rd_ptr == PTR_W'(NUM_RW + 1)) rd_data = ID_LO;
  end

  assign grp_sdram = rw_q[2];
  assign grp_pci   = rw_q[3];
  assign grp_misc  = rw_q[4];
  assign grp_cpu   = rw_q[5];

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rw_flat == init_flat));

  // R5 R6
  ro_write_discard_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= PTR_W'(NUM_RW)) |=> $stable(rw_flat));
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [11:0] sdram_en_o,
  output logic        sdram_free_en_o,
  output logic [7:0]  pci_en_o,
  output logic [2:0]  mid_en_o,
  output logic [1:0]  cpu_en_o,
  output logic [2:0]  cpu_sdram_skew_o,
  output logic [2:0]  cpu_mid_skew_o
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [BYTE_W-1:0] grp_sdram, grp_pci, grp_misc, grp_cpu;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_byte_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
    .clk(clk), .rst(rst), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_ptr(rd_ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  ctlreg_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data),
    .grp_sdram(grp_sdram), .grp_pci(grp_pci), .grp_misc(grp_misc), .grp_cpu(grp_cpu)
  );

  assign sdram_en_o       = {grp_misc[4:1], grp_sdram};
  assign sdram_free_en_o  = grp_misc[0];
  assign pci_en_o         = grp_pci;
  assign mid_en_o         = grp_misc[7:5];
  assign cpu_en_o         = grp_cpu[1:0];
  assign cpu_sdram_skew_o = grp_cpu[7:5];
  assign cpu_mid_skew_o   = grp_cpu[4:2];
endmodule

// File: tb/sim_clkgen_ctrl_regs.sv
module sim_clkgen_ctrl_regs;
  localparam logic [6:0] DEV = 7'h69;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [11:0] sdram_en;
  logic sdram_free_en;
  logic [7:0] pci_en;
  logic [2:0] mid_en, sk_sd, sk_mid;
  logic [1:0] cpu_en;
  assign sda_line = sda_m & ~sda_oe;

  clkgen_ctrl_regs #(.SLAVE_ADDR(DEV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sdram_en_o(sdram_en), .sdram_free_en_o(sdram_free_en), .pci_en_o(pci_en),
    .mid_en_o(mid_en), .cpu_en_o(cpu_en), .cpu_sdram_skew_o(sk_sd),
    .cpu_mid_skew_o(sk_mid)
  );

  int n_run = 0, n_fail = 0, r11_viol = 0;
  logic [7:0] model [13];
  logic [7:0] dbuf [32];
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      2, 3, 4: return 8'hFF;
      5:       return 8'h93;
      7:       return 8'h20;
      11:      return 8'h50;
      12:      return 8'h12;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    return (i < 13) ? model[i] : 8'hFF;
  endfunction

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); hq(); sda_m = 0; hq(); scl_m = 0; endtask
  task automatic bus_rstart(); hq(); sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; endtask
  task automatic bus_stop(); hq(); sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq(); endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      hq(); sda_m = b[i]; hq(); scl_m = 1; hq(); hq(); scl_m = 0;
    end
    hq(); sda_m = 1; hq(); scl_m = 1; hq(); ack = ~sda_line; hq(); scl_m = 0;
  endtask

  task automatic rbyte(input bit last, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hq(); hq(); scl_m = 1; hq(); b = {b[6:0], sda_line}; hq(); scl_m = 0;
    end
    hq(); sda_m = last; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq(); sda_m = 1;
  endtask

  // header + n data bytes from dbuf; ends with STOP or repeated START
  task automatic wframe(input logic [6:0] a, input int n, input bit exp_ack,
                        input bit skip_start, input bit end_rs);
    logic ack;
    if (!skip_start) bus_start();
    wbyte({a, 1'b0}, ack);
    chk("R2 address ack", ack, exp_ack);
    wbyte(8'($urandom), ack); chk("R3 command ack", ack, exp_ack);
    wbyte(8'($urandom), ack); chk("R3 count ack", ack, exp_ack);
    for (int i = 0; i < n; i++) begin
      wbyte(dbuf[i], ack);
      if (i < 11)      chk("R4 data ack", ack, exp_ack);
      else if (i < 13) chk("R5 id write ack", ack, exp_ack);
      else             chk("R6 overflow ack", ack, exp_ack);
      if (exp_ack && i < 11) model[i] = dbuf[i];
    end
    if (end_rs) bus_rstart(); else bus_stop();
  endtask

  task automatic rframe(input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    wbyte({DEV, 1'b1}, ack);
    chk("R8 read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, b);
      if (i == 11 || i == 12) chk("R5 id readback", b, exp_rd(i));
      else                    chk("R8 R4 readback", b, exp_rd(i));
    end
    bus_stop();
  endtask

  task automatic chk_out();
    chk("R9 sdram enables", sdram_en, {model[4][4:1], model[2]});
    chk("R9 free sdram enable", sdram_free_en, model[4][0]);
    chk("R9 pci enables", pci_en, model[3]);
    chk("R9 mid enables", mid_en, model[4][7:5]);
    chk("R10 cpu enables", cpu_en, model[5][1:0]);
    chk("R10 sdram skew", sk_sd, model[5][7:5]);
    chk("R10 mid skew", sk_mid, model[5][4:2]);
  endtask

  // R11 monitor: the open-drain enable must not move while SCL stays high
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl_m && scl_prev && (sda_oe !== oe_prev)) r11_viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 13; i++) model[i] = rst_val(i);
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // R1 reset state at the ports and over the bus
    chk("R1 sda released", sda_oe, 1'b0);
    chk_out();
    rframe(13);

    // R2 foreign address: no ack, registers untouched
    for (int i = 0; i < 4; i++) dbuf[i] = 8'hA5;
    wframe(7'h2A, 4, 1'b0, 1'b0, 1'b0);
    rframe(4);

    // R3 header ignored, data starts at register 0
    dbuf[0] = 8'h3C;
    wframe(DEV, 1, 1'b1, 1'b0, 1'b0);
    rframe(1);

    // R4 R5 R6 full frame past the end
    for (int i = 0; i < 16; i++) dbuf[i] = 8'(8'h11 * i + 8'h07);
    wframe(DEV, 16, 1'b1, 1'b0, 1'b0);
    chk_out();
    rframe(16);

    // R7 repeated START resets the pointer
    dbuf[0] = 8'hC3; dbuf[1] = 8'h5A;
    wframe(DEV, 2, 1'b1, 1'b0, 1'b1);
    dbuf[0] = 8'h96;
    wframe(DEV, 1, 1'b1, 1'b1, 1'b0);
    rframe(3);

    // R7 STOP resets the pointer
    dbuf[0] = 8'h0F;
    wframe(DEV, 1, 1'b1, 1'b0, 1'b0);
    rframe(2);

    // constrained random frames
    for (int r = 0; r < 10; r++) begin
      int n;
      n = 1 + int'($urandom % 15);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      wframe(DEV, n, 1'b1, 1'b0, 1'b0);
      chk_out();
      rframe(1 + int'($urandom % 15));
    end

    chk("R11 sda change while scl high", r11_viol, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule